// File: doc/BRIEF.md
# Operand Effective Address Generator

This block computes the 16-bit operand address for an 8-bit processor core once the opcode has been decoded. A start strobe delivers the addressing mode, a flag for the bit-test-and-branch form of direct addressing, and the current index register. The block then pulls the bytes that follow the opcode from a byte stream with a valid/ready handshake. It takes as many bytes as the mode needs and then pulses a done strobe.

The done strobe comes with the effective address, the full instruction length in bytes (opcode included) and, for bit-test-and-branch, the branch displacement byte unchanged. Every mode except extended yields a zero-page style address: the high byte is zero, or bit 8 alone when an indexed sum carries.

Top module: `oper_ea_gen`

## Requirements
- R1: With mode 0 (direct) and the branch flag low, one operand byte is consumed; at done the address is {8'h00, byte} and the count is 2.
- R2: With mode 1 (extended), two operand bytes are consumed; at done the address is {first byte, second byte} and the count is 3.
- R3: With mode 2 (indexed, no offset), no operand byte is consumed, ready stays low, done is high in the cycle after start, the address is {8'h00, index} and the count is 1.
- R4: With mode 3 (indexed, 8-bit offset), one byte is consumed; the address is the 9-bit unsigned sum index + byte, zero-extended, so it never exceeds 16'h01FE; the count is 2.
- R5: With mode 0 and the branch flag high, two bytes are consumed; the address is {8'h00, first byte}, the displacement output equals the second byte and the count is 3.
- R6: A byte is taken only in a cycle where valid and ready are both high; ready is low while idle and in the done cycle, so valid is ignored there.
- R7: Start is ignored while an operation is in progress, and the running result is unaffected.
- R8: Done is high for exactly one cycle per operation, and the address, count and displacement are valid in that cycle.
- R9: A synchronous active-high reset returns the block to idle with done and ready low, also in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 2 | Addressing mode: 0 direct, 1 extended, 2 indexed no offset, 3 indexed 8-bit offset |
| bitBranch | input | 1 | Direct mode is a bit-test-and-branch instruction |
| indexReg | input | 8 | Index register value, sampled at start |
| byteData | input | 8 | Instruction byte following the opcode |
| byteValid | input | 1 | byteData holds a byte |
| byteReady | output | 1 | Block accepts a byte this cycle |
| done | output | 1 | One-cycle completion strobe |
| effAddr | output | 16 | Effective operand address |
| byteCount | output | 2 | Instruction length including opcode (1 to 3) |
| branchDisp | output | 8 | Passed-through branch displacement |

## Verification
The bench sweeps the indexed-offset sum over a grid that includes the index/offset pair FF+FF. A design that drops the carry would return 00FE there, and one that sign-extends would set the upper byte. It sweeps all 256 index values with no offset. A design that pulls a byte in that mode would show a nonzero consumed count or a late done. Byte gaps, start pulses mid-operation and a reset in the middle of an extended fetch are also applied. A block that latched bytes without ready, restarted on a busy start, or kept a stale state after reset would return a wrong address or a wrong length. The bit-test-and-branch case checks that the displacement is not merged into the address.

// File: rtl/oper_ea_pkg.sv
package oper_ea_pkg;

  typedef enum logic [1:0] {
    EA_DIR = 2'd0,
    EA_EXT = 2'd1,
    EA_IXN = 2'd2,
    EA_IX8 = 2'd3
  } eaMode_e;

  localparam int MAX_OPS = 2;
  localparam int CNT_W   = $clog2(MAX_OPS + 2);

  typedef struct packed {
    logic capture;
    logic ldFirst;
    logic ldSecond;
  } eaCtrl_t;

  function automatic logic [CNT_W-1:0] opBytes(eaMode_e m, logic br);
    case (m)
      EA_DIR:  opBytes = br ? CNT_W'(2) : CNT_W'(1);
      EA_EXT:  opBytes = CNT_W'(2);
      EA_IXN:  opBytes = CNT_W'(0);
      default: opBytes = CNT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/oper_ea_ctrl.sv
module oper_ea_ctrl
  import oper_ea_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  eaMode_e modeIn,
  input  logic    bitBranch,
  input  logic    byteValid,
  output logic    byteReady,
  output logic    done,
  output eaCtrl_t ctrl
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_FINISH} state_e;

  state_e          stateQ;
  logic [CNT_W-1:0] leftQ;
  logic            firstQ;
  logic [CNT_W-1:0] need;
  logic            accept;

  assign need      = opBytes(modeIn, bitBranch);
  assign byteReady = (stateQ == ST_FETCH);
  assign done      = (stateQ == ST_FINISH);
  assign accept    = byteReady && byteValid;

  always_comb begin
    ctrl.capture  = (stateQ == ST_IDLE) && start;
    ctrl.ldFirst  = accept && firstQ;
    ctrl.ldSecond = accept && !firstQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      leftQ  <= '0;
      firstQ <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (start) begin
          leftQ  <= need;
          firstQ <= 1'b1;
          stateQ <= (need == '0) ? ST_FINISH : ST_FETCH;
        end
        ST_FETCH: if (accept) begin
          firstQ <= 1'b0;
          leftQ  <= leftQ - 1'b1;
          if (leftQ == CNT_W'(1)) stateQ <= ST_FINISH;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/oper_ea_dpath.sv
module oper_ea_dpath
  import oper_ea_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  eaCtrl_t           ctrl,
  input  eaMode_e           modeIn,
  input  logic              bitBranch,
  input  logic [DATA_W-1:0] indexReg,
  input  logic [DATA_W-1:0] byteData,
  output logic [ADDR_W-1:0] effAddr,
  output logic [1:0]        byteCount,
  output logic [DATA_W-1:0] branchDisp
);

  localparam int SUM_W = DATA_W + 1;

  eaMode_e           modeQ;
  logic              brQ;
  logic [DATA_W-1:0] idxQ, hiQ, loQ, dispQ;
  logic [SUM_W-1:0]  idxSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= EA_DIR;
      brQ   <= 1'b0;
      idxQ  <= '0;
      hiQ   <= '0;
      loQ   <= '0;
      dispQ <= '0;
    end else if (ctrl.capture) begin
      modeQ <= modeIn;
      brQ   <= bitBranch && (modeIn == EA_DIR);
      idxQ  <= indexReg;
      hiQ   <= '0;
      loQ   <= '0;
      dispQ <= '0;
    end else if (ctrl.ldFirst) begin
      if (modeQ == EA_EXT) hiQ <= byteData;
      else                 loQ <= byteData;
    end else if (ctrl.ldSecond) begin
      if (modeQ == EA_EXT) loQ   <= byteData;
      else                 dispQ <= byteData;
    end
  end

  assign idxSum = SUM_W'(idxQ) + SUM_W'(loQ);

  always_comb begin
    case (modeQ)
      EA_DIR:  effAddr = ADDR_W'(loQ);
      EA_EXT:  effAddr = ADDR_W'({hiQ, loQ});
      EA_IXN:  effAddr = ADDR_W'(idxQ);
      default: effAddr = ADDR_W'(idxSum);
    endcase
    byteCount  = 2'(opBytes(modeQ, brQ)) + 2'd1;
    branchDisp = dispQ;
  end

endmodule

// File: rtl/oper_ea_gen.sv
module oper_ea_gen
  import oper_ea_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              bitBranch,
  input  logic [DATA_W-1:0] indexReg,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteValid,
  output logic              byteReady,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic [1:0]        byteCount,
  output logic [DATA_W-1:0] branchDisp
);

  eaCtrl_t ctrl;
  eaMode_e modeIn;

  assign modeIn = eaMode_e'(mode);

  oper_ea_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start), .modeIn(modeIn),
    .bitBranch(bitBranch), .byteValid(byteValid),
    .byteReady(byteReady), .done(done), .ctrl(ctrl)
  );

  oper_ea_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .modeIn(modeIn),
    .bitBranch(bitBranch), .indexReg(indexReg), .byteData(byteData),
    .effAddr(effAddr), .byteCount(byteCount), .branchDisp(branchDisp)
  );

endmodule

// File: rtl/oper_ea_chk.sv
module oper_ea_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        mode,
  input logic              byteReady,
  input logic              done,
  input logic [ADDR_W-1:0] effAddr,
  input logic [1:0]        byteCount
);

  logic [1:0] modeSeen;
  logic       idle;

  assign idle = !byteReady && !done;

  always_ff @(posedge clk) begin
    if (rst)                modeSeen <= 2'd0;
    else if (start && idle) modeSeen <= mode;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !byteReady); // R6
  AST_IXN_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (start && idle && mode == 2'd2) |=> (done && !$past(byteReady))); // R3
  AST_ZERO_PAGE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && modeSeen != 2'd1) |-> (effAddr <= ADDR_W'(16'h01FE))); // R4
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (byteCount != 2'd0)); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!done && !byteReady)); // R9

endmodule

bind oper_ea_gen oper_ea_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .byteReady(byteReady),
  .done(done), .effAddr(effAddr), .byteCount(byteCount)
);

// File: tb/oper_ea_gen_tb_top.sv
`timescale 1ns/1ps
module oper_ea_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst, start, bitBranch, byteValid;
  logic [1:0]  mode;
  logic [7:0]  indexReg, byteData;
  logic        byteReady, done;
  logic [15:0] effAddr;
  logic [1:0]  byteCount;
  logic [7:0]  branchDisp;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  oper_ea_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .bitBranch(bitBranch),
    .indexReg(indexReg), .byteData(byteData), .byteValid(byteValid),
    .byteReady(byteReady), .done(done), .effAddr(effAddr),
    .byteCount(byteCount), .branchDisp(branchDisp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One full operation; stall inserts valid gaps, poke pulses start while busy.
  task automatic runOp(input logic [1:0] m, input logic br, input logic [7:0] x,
                       input logic [7:0] b0, input logic [7:0] b1,
                       input bit stall, input bit poke, input string req);
    int needed, consumed, cyc, expCnt;
    logic [15:0] expAddr;
    bit accPrev, got;
    case (m)
      2'd0: begin needed = br ? 2 : 1; expAddr = {8'h00, b0}; end
      2'd1: begin needed = 2; expAddr = {b0, b1}; end
      2'd2: begin needed = 0; expAddr = {8'h00, x}; end
      default: begin needed = 1; expAddr = 16'(x) + 16'(b0); end
    endcase
    expCnt = needed + 1;
    @(negedge clk);
    start = 1'b1; mode = m; bitBranch = br; indexReg = x;
    byteValid = 1'b0;
    consumed = 0; cyc = 0; got = 0; accPrev = 0;
    while (!got && cyc < 40) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == 1 && m != 2'd2);
      mode = ~m; bitBranch = ~br; indexReg = ~x;
      if (accPrev) consumed++;
      if (done) begin
        got = 1;
        chk(effAddr == expAddr, req, effAddr, expAddr);
        chk(byteCount == 2'(expCnt), req, byteCount, expCnt);
        chk(consumed == needed, {req, " R6 bytes"}, consumed, needed);
        if (m == 2'd0 && br) chk(branchDisp == b1, "R5 disp", branchDisp, b1);
        if (m == 2'd2) chk(cyc == 1, "R3 latency", cyc, 1);
        byteValid = 1'b0;
      end else begin
        byteValid = !(stall && (cyc % 2 == 1));
        byteData  = (consumed == 0) ? b0 : ((consumed == 1) ? b1 : 8'hEE);
        accPrev   = byteValid && byteReady;
      end
    end
    if (!got) chk(1'b0, {req, " no done"}, 0, 1);
    start = 1'b0;
    @(negedge clk);
    chk(!done, "R8 single pulse", done, 0);
    chk(!byteReady, "R6 idle ready", byteReady, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; mode = 2'd0; bitBranch = 1'b0;
    indexReg = 8'h00; byteData = 8'h00; byteValid = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && !byteReady, "R9 reset state", {done, byteReady}, 0);
    rst = 1'b0;
    // R6: valid high while idle must not be taken
    byteData = 8'h5A;
    repeat (3) begin
      @(negedge clk);
      chk(!byteReady, "R6 idle ignores valid", byteReady, 0);
    end
    byteValid = 1'b0;

    for (int v = 0; v < 256; v++)
      runOp(2'd0, 1'b0, 8'(v * 7), 8'(v), 8'hC3, v % 3 == 0, 0, "R1 direct");
    for (int v = 0; v < 256; v += 5)
      runOp(2'd1, 1'b0, 8'h11, 8'(v), 8'(255 - v), v % 2 == 0, 0, "R2 extended");
    runOp(2'd1, 1'b0, 8'h00, 8'hFF, 8'hFF, 0, 0, "R2 extended max");
    for (int v = 0; v < 256; v++)
      runOp(2'd2, v[0], 8'(v), 8'hAA, 8'hBB, 1, 0, "R3 indexed");
    for (int i = 0; i < 256; i += 15)
      for (int j = 0; j < 256; j += 15)
        runOp(2'd3, 1'b0, 8'(i), 8'(j), 8'h77, (i + j) % 2 == 1, 0, "R4 ix8");
    runOp(2'd3, 1'b0, 8'hFF, 8'hFF, 8'h00, 0, 0, "R4 ix8 max 01FE");
    runOp(2'd3, 1'b0, 8'h01, 8'hFF, 8'h00, 0, 0, "R4 ix8 carry");
    for (int v = 0; v < 256; v += 9)
      runOp(2'd0, 1'b1, 8'h33, 8'(v), 8'(v ^ 8'h96), v % 2 == 0, 0, "R5 branch");

    runOp(2'd1, 1'b0, 8'h00, 8'h12, 8'h34, 1, 1, "R7 busy start ext");
    runOp(2'd0, 1'b1, 8'h00, 8'h9C, 8'hF0, 0, 1, "R7 busy start branch");
    runOp(2'd3, 1'b0, 8'h80, 8'h90, 8'h00, 1, 1, "R7 busy start ix8");

    // R9: reset in the middle of an extended fetch
    @(negedge clk);
    start = 1'b1; mode = 2'd1; indexReg = 8'h00;
    @(negedge clk);
    start = 1'b0; byteValid = 1'b1; byteData = 8'hAB;
    @(negedge clk);
    byteValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!done && !byteReady, "R9 mid-op reset", {done, byteReady}, 0);
    runOp(2'd0, 1'b0, 8'h00, 8'h42, 8'h00, 0, 0, "R9 after reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule